// File: doc/BRIEF.md
# GPIO Interrupt Unit

This block controls 32 general-purpose pins that can each raise an interrupt. Software reaches it over a small 16-bit register bus. Every setting is split into a pair of 16-bit registers: the lower register serves pins 0 to 15 and the upper one, two bytes higher, serves pins 16 to 31. For each pin, software sets the direction and the output value. It also sets whether the pin may interrupt, whether it triggers on a level or an edge, which level counts as active, whether an edge is held until cleared, and which edges count.

Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the one before it. Detected events land in a per-pin status register that software clears by writing ones. The pending set is status AND enable. A registered OR of that set drives a single interrupt line. An encoder also reports the index of the pending pin with the highest priority, and raises a flag when nothing is pending.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset every register is 0. All pins are inputs (`pin_oe` = 0, `pin_out` = 0), `irq_out` is 0, `pend_none` is 1 and `pend_idx` is 0.
- R2: Byte offsets select the registers: 0x00 direction, 0x04 pin data, 0x08 status, 0x0C enable, 0x10 trigger type, 0x14 active level, 0x18 hold, 0x20 falling inhibit and 0x24 rising inhibit. Adding 2 to an offset selects pins 16-31. A write reaches `pin_oe` / `pin_out` at the next clock edge, with direction 1 meaning output. Read data is registered and appears the cycle after `bus_rd`. Unmapped offsets read as 0.
- R3: A read of the pin data register returns the output latch for output pins and the synchronised pin level for input pins.
- R4: With trigger type 0 (level), the status bit follows the synchronised pin. It is 1 while the pin equals its active-level bit (1 = active high, 0 = active low). A clear write while the pin is active has no lasting effect. After reset this means active low, so pins held low read as status 1.
- R5: With trigger type 1 and hold 1, a qualifying edge sets the status bit, and the bit stays set until a 1 is written to it. Writing 0 leaves it unchanged.
- R6: With trigger type 1 and hold 0, an edge sets status for exactly one cycle. An enabled pin therefore gives a single-cycle `irq_out` pulse.
- R7: Edge selection works as follows. With only the falling-inhibit bit set, only rising edges count. With only the rising-inhibit bit set, only falling edges count. With both bits set, or neither, both edges count.
- R8: Clearing an enable bit removes that pin from the pending set and from `irq_out`. It leaves the pin's status bit unchanged.
- R9: `pend_idx` gives the lowest pending pin in pins 0-15. It looks at pins 16-31 only when none of pins 0-15 is pending. With nothing pending, `pend_none` is 1 and `pend_idx` is 0.
- R10: `irq_out` equals the OR of all pending bits, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt, registered |
| pend_idx | output | 5 | Index of the top-priority pending pin |
| pend_none | output | 1 | No pin pending |

## Verification
The assertions check the following on every cycle:
- the reset values;
- a direction write reaching `pin_oe`;
- the one-cycle relation between the pending flag and `irq_out`;
- that the reported index is really pending;
- that the low bank wins;
- that an all-zero enable leaves nothing pending.

Only the bench scenarios can show the rest: level polarity, hold versus pass-through capture, the four inhibit combinations, write-one-to-clear against a still-active level, masking that preserves status, and the data read mixing latch and pin values.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    localparam int BANK_W     = 16;
    localparam int N_BANKS    = 2;
    localparam int N_PINS     = BANK_W * N_BANKS;
    localparam int IDX_W      = $clog2(N_PINS);
    localparam int LIDX_W     = $clog2(BANK_W);
    localparam int BSEL_W     = $clog2(N_BANKS);
    localparam int ADDR_W     = 6;

    // Register selector taken from byte offset bits [5:2]
    typedef enum logic [3:0] {
        F_DIR  = 4'd0,
        F_DATA = 4'd1,
        F_STAT = 4'd2,
        F_IEN  = 4'd3,
        F_TYPE = 4'd4,
        F_POL  = 4'd5,
        F_HOLD = 4'd6,
        F_RSV  = 4'd7,
        F_FINH = 4'd8,
        F_RINH = 4'd9
    } field_e;

    typedef struct packed {
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] dout;
        logic [N_PINS-1:0] ien;
        logic [N_PINS-1:0] ttype;
        logic [N_PINS-1:0] apol;
        logic [N_PINS-1:0] hold;
        logic [N_PINS-1:0] finh;
        logic [N_PINS-1:0] rinh;
    } cfg_t;

    // Rising edges count unless only the rising inhibit is set
    function automatic logic rise_ok(logic f, logic r);
        return !(r && !f);
    endfunction

    // Falling edges count unless only the falling inhibit is set
    function automatic logic fall_ok(logic f, logic r);
        return !(f && !r);
    endfunction

    function automatic logic [N_PINS-1:0] put_half(logic [N_PINS-1:0] v, logic hi,
                                                   logic [BANK_W-1:0] d);
        logic [N_PINS-1:0] r;
        r = v;
        if (hi) r[N_PINS-1:BANK_W] = d;
        else    r[BANK_W-1:0]      = d;
        return r;
    endfunction

    function automatic logic [BANK_W-1:0] get_half(logic [N_PINS-1:0] v, logic hi);
        return hi ? v[N_PINS-1:BANK_W] : v[BANK_W-1:0];
    endfunction

    function automatic logic [LIDX_W-1:0] lowest_set(logic [BANK_W-1:0] v);
        logic [LIDX_W-1:0] r;
        r = '0;
        for (int i = BANK_W - 1; i >= 0; i--)
            if (v[i]) r = LIDX_W'(i);
        return r;
    endfunction

endpackage

// File: rtl/pin_event_regs.sv
module pin_event_regs
    import pin_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BANK_W-1:0] wdata,
    input  logic              rd,
    input  logic [N_PINS-1:0] status,
    input  logic [N_PINS-1:0] pin_sync,
    output cfg_t              cfg,
    output logic [N_PINS-1:0] clr,
    output logic [BANK_W-1:0] rdata
);

    field_e             fld;
    logic               hi;
    logic               unused_a0;
    logic [N_PINS-1:0]  data_view;
    logic [BANK_W-1:0]  rd_mux;

    assign fld       = field_e'(addr[5:2]);
    assign hi        = addr[1];
    assign unused_a0 = addr[0];

    // Output pins show their latch, input pins show the synchronised level
    assign data_view = (cfg.dir & cfg.dout) | (~cfg.dir & pin_sync);

    assign clr = (wr && fld == F_STAT) ? put_half('0, hi, wdata) : '0;

    always_comb begin
        case (fld)
            F_DIR:   rd_mux = get_half(cfg.dir, hi);
            F_DATA:  rd_mux = get_half(data_view, hi);
            F_STAT:  rd_mux = get_half(status, hi);
            F_IEN:   rd_mux = get_half(cfg.ien, hi);
            F_TYPE:  rd_mux = get_half(cfg.ttype, hi);
            F_POL:   rd_mux = get_half(cfg.apol, hi);
            F_HOLD:  rd_mux = get_half(cfg.hold, hi);
            F_FINH:  rd_mux = get_half(cfg.finh, hi);
            F_RINH:  rd_mux = get_half(cfg.rinh, hi);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            rdata <= '0;
        end else begin
            if (wr) begin
                case (fld)
                    F_DIR:   cfg.dir   <= put_half(cfg.dir, hi, wdata);
                    F_DATA:  cfg.dout  <= put_half(cfg.dout, hi, wdata);
                    F_IEN:   cfg.ien   <= put_half(cfg.ien, hi, wdata);
                    F_TYPE:  cfg.ttype <= put_half(cfg.ttype, hi, wdata);
                    F_POL:   cfg.apol  <= put_half(cfg.apol, hi, wdata);
                    F_HOLD:  cfg.hold  <= put_half(cfg.hold, hi, wdata);
                    F_FINH:  cfg.finh  <= put_half(cfg.finh, hi, wdata);
                    F_RINH:  cfg.rinh  <= put_half(cfg.rinh, hi, wdata);
                    default: ;
                endcase
            end
            if (rd) rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
    import pin_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] ttype,
    input  logic [N_PINS-1:0] apol,
    input  logic [N_PINS-1:0] hold,
    input  logic [N_PINS-1:0] finh,
    input  logic [N_PINS-1:0] rinh,
    input  logic [N_PINS-1:0] clr,
    output logic [N_PINS-1:0] status,
    output logic [N_PINS-1:0] pin_sync
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic s1, s2, prev;
        logic rise, fall, ev, lvl;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= pin_in[i];
                s2   <= s1;
                prev <= s2;
            end
        end

        assign rise = s2 & ~prev;
        assign fall = ~s2 & prev;
        assign ev   = (rise & rise_ok(finh[i], rinh[i])) |
                      (fall & fall_ok(finh[i], rinh[i]));
        assign lvl  = (s2 == apol[i]);

        always_ff @(posedge clk) begin
            if (rst)           status[i] <= 1'b0;
            else if (!ttype[i]) status[i] <= lvl;
            else if (hold[i])   status[i] <= (status[i] & ~clr[i]) | ev;
            else                status[i] <= ev;
        end

        assign pin_sync[i] = s2;
    end

endmodule

// File: rtl/pin_event_prio.sv
module pin_event_prio
    import pin_event_pkg::*;
(
    input  logic [N_PINS-1:0]        pend,
    output logic [IDX_W-1:0]         idx,
    output logic                     none
);

    logic [N_BANKS-1:0]        bank_any;
    logic [N_BANKS*LIDX_W-1:0] bank_idx;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] v;
        assign v = pend[b*BANK_W +: BANK_W];
        assign bank_any[b] = |v;
        assign bank_idx[b*LIDX_W +: LIDX_W] = lowest_set(v);
    end

    // Lower bank number wins: scan from the top so the lowest overwrites
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int b = N_BANKS - 1; b >= 0; b--) begin
            if (bank_any[b]) begin
                idx  = {b[BSEL_W-1:0], bank_idx[b*LIDX_W +: LIDX_W]};
                none = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
    import pin_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic              irq_out,
    output logic [4:0]        pend_idx,
    output logic              pend_none
);

    cfg_t              cfg;
    logic [N_PINS-1:0] clr;
    logic [N_PINS-1:0] status;
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] pend;

    pin_event_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rd       (bus_rd),
        .status   (status),
        .pin_sync (pin_sync),
        .cfg      (cfg),
        .clr      (clr),
        .rdata    (bus_rdata)
    );

    pin_event_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .ttype    (cfg.ttype),
        .apol     (cfg.apol),
        .hold     (cfg.hold),
        .finh     (cfg.finh),
        .rinh     (cfg.rinh),
        .clr      (clr),
        .status   (status),
        .pin_sync (pin_sync)
    );

    assign pend = status & cfg.ien;

    pin_event_prio u_prio (
        .pend (pend),
        .idx  (pend_idx),
        .none (pend_none)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |pend;
    end

    assign pin_out = cfg.dout;
    assign pin_oe  = cfg.dir;

endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk
    import pin_event_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [5:0]        bus_addr,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [31:0]       pin_oe,
    input logic              irq_out,
    input logic [4:0]        pend_idx,
    input logic              pend_none,
    input logic [N_PINS-1:0] pend,
    input logic [N_PINS-1:0] ien
);

    // R1: the first cycle after reset shows cleared outputs
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_out && bus_rdata == 16'h0 && pin_oe == 32'h0));

    // R2: a low-half direction write shows on pin_oe one edge later
    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[5:1] == 5'd0) |=> (pin_oe[15:0] == $past(bus_wdata)));

    // R10: irq_out follows the pending flag by one clock
    p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
        !pend_none |=> irq_out);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        pend_none |=> !irq_out);

    // R9: the reported index is a pending pin
    p_idx_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !pend_none |-> pend[pend_idx]);

    // R9: a low-bank pending pin always wins
    p_low_first_r9: assert property (@(posedge clk) disable iff (rst)
        (|pend[BANK_W-1:0]) |-> (int'(pend_idx) < BANK_W));

    // R9: nothing pending reports index 0
    p_none_zero_r9: assert property (@(posedge clk) disable iff (rst)
        pend_none |-> (pend_idx == 5'd0 && pend == '0));

    // R8: with every enable cleared nothing is pending
    p_mask_all_r8: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> pend_none);

endmodule

bind pin_event_ctrl pin_event_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .pend_idx  (pend_idx),
    .pend_none (pend_none),
    .pend      (pend),
    .ien       (cfg.ien)
);

// File: tb/pin_event_ctrl_bench.sv
`timescale 1ns/1ps
module pin_event_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic        bus_rd;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;
    logic [4:0]  pend_idx;
    logic        pend_none;

    always #10 clk = ~clk;

    pin_event_ctrl u_pin_event_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out),
        .pend_idx  (pend_idx),
        .pend_none (pend_none)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    logic  rd_q  = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: a read issued last cycle is compared now
    always @(posedge clk) rd_q <= bus_rd;

    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                check("read without expectation", 32'h1, 32'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {16'h0, bus_rdata}, {16'h0, e});
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(logic [5:0] a, logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(logic [5:0] a, logic [15:0] e, string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        bus_rd = 1'b0; pin_in = '0;
        tick(4);
        check("R1 pin_oe in reset", pin_oe, 32'h0);
        rst = 1'b0;
        tick(4);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);
        check("R1 pend_none", {31'h0, pend_none}, 32'h1);
        check("R1 pend_idx", {27'h0, pend_idx}, 32'h0);
        rd_reg(6'h00, 16'h0000, "R1 direction reads 0");
        rd_reg(6'h10, 16'h0000, "R1 trigger type reads 0");
        // default level, active low, pins low: status all ones
        rd_reg(6'h08, 16'hFFFF, "R4 reset status low bank");
        rd_reg(6'h0A, 16'hFFFF, "R4 reset status high bank");

        // R2 direction and data halves
        wr_reg(6'h00, 16'h00FF);
        wr_reg(6'h02, 16'hF000);
        check("R2 pin_oe", pin_oe, 32'hF000_00FF);
        wr_reg(6'h04, 16'h1234);
        wr_reg(6'h06, 16'hABCD);
        check("R2 pin_out", pin_out, 32'hABCD_1234);
        rd_reg(6'h02, 16'hF000, "R2 direction high readback");
        rd_reg(6'h1C, 16'h0000, "R2 unmapped reads 0");
        pin_in = 32'h0F0F_5500;
        tick(3);
        rd_reg(6'h04, 16'h5534, "R3 data low mix");
        rd_reg(6'h06, 16'hAF0F, "R3 data high mix");
        pin_in = '0;
        wr_reg(6'h00, 16'h0000);
        wr_reg(6'h02, 16'h0000);
        tick(3);

        // R4 level mode, active high everywhere
        wr_reg(6'h14, 16'hFFFF);
        wr_reg(6'h16, 16'hFFFF);
        tick(1);
        rd_reg(6'h08, 16'h0000, "R4 active high, pins low");
        wr_reg(6'h0C, 16'h0001);
        pin_in[0] = 1'b1;
        tick(3);
        check("R9 idx pin0", {27'h0, pend_idx}, 32'h0);
        check("R10 pending seen", {31'h0, pend_none}, 32'h0);
        check("R10 irq not yet", {31'h0, irq_out}, 32'h0);
        tick(1);
        check("R10 irq one cycle later", {31'h0, irq_out}, 32'h1);
        wr_reg(6'h08, 16'h0001);
        tick(1);
        rd_reg(6'h08, 16'h0001, "R4 clear while active has no effect");
        pin_in[0] = 1'b0;
        tick(4);
        check("R4 level released irq", {31'h0, irq_out}, 32'h0);
        check("R4 level released none", {31'h0, pend_none}, 32'h1);
        // active low on pin1
        wr_reg(6'h14, 16'hFFFD);
        wr_reg(6'h0C, 16'h0002);
        tick(2);
        check("R4 active low irq", {31'h0, irq_out}, 32'h1);
        check("R4 active low idx", {27'h0, pend_idx}, 32'h1);
        wr_reg(6'h14, 16'hFFFF);
        wr_reg(6'h0C, 16'h0000);
        tick(2);

        // R5 / R7 edge hold on pins 4..7
        wr_reg(6'h20, 16'h0050);   // falling inhibit: pins 4, 6
        wr_reg(6'h24, 16'h0060);   // rising inhibit: pins 5, 6
        wr_reg(6'h10, 16'h00F0);
        wr_reg(6'h18, 16'h00F0);
        tick(2);
        pin_in[7:4] = 4'hF;
        tick(3);
        rd_reg(6'h08, 16'h00D0, "R7 rising edges counted");
        wr_reg(6'h08, 16'h00F0);
        rd_reg(6'h08, 16'h0000, "R5 clear by writing one");
        pin_in[7:4] = 4'h0;
        tick(3);
        rd_reg(6'h08, 16'h00E0, "R7 falling edges counted");
        wr_reg(6'h08, 16'h0000);
        rd_reg(6'h08, 16'h00E0, "R5 writing zero keeps status");

        // R8 masking
        wr_reg(6'h0C, 16'h0080);
        tick(1);
        check("R8 enabled irq", {31'h0, irq_out}, 32'h1);
        check("R8 enabled idx", {27'h0, pend_idx}, 32'h7);
        wr_reg(6'h0C, 16'h0000);
        check("R8 masked none", {31'h0, pend_none}, 32'h1);
        tick(1);
        check("R8 masked irq", {31'h0, irq_out}, 32'h0);
        rd_reg(6'h08, 16'h00E0, "R8 status kept after mask");
        wr_reg(6'h08, 16'h00F0);

        // R9 encoder across banks
        wr_reg(6'h12, 16'hFFFF);
        wr_reg(6'h1A, 16'hFFFF);
        wr_reg(6'h0E, 16'hFFFF);
        wr_reg(6'h0C, 16'h0040);
        tick(2);
        pin_in[18] = 1'b1;
        pin_in[20] = 1'b1;
        tick(3);
        check("R9 high bank idx", {27'h0, pend_idx}, 32'd18);
        check("R10 irq lags pending", {31'h0, irq_out}, 32'h0);
        tick(1);
        check("R10 irq high bank", {31'h0, irq_out}, 32'h1);
        pin_in[6] = 1'b1;
        tick(3);
        check("R9 low bank wins", {27'h0, pend_idx}, 32'd6);
        wr_reg(6'h08, 16'h0040);
        check("R9 back to high bank", {27'h0, pend_idx}, 32'd18);
        wr_reg(6'h0A, 16'h0004);
        check("R9 next high pin", {27'h0, pend_idx}, 32'd20);
        wr_reg(6'h0A, 16'h0010);
        check("R9 none flag", {31'h0, pend_none}, 32'h1);
        check("R9 none idx", {27'h0, pend_idx}, 32'h0);
        tick(1);
        check("R10 irq drops", {31'h0, irq_out}, 32'h0);

        // R6 pass-through on pin9
        wr_reg(6'h10, 16'h02F0);
        wr_reg(6'h0C, 16'h0200);
        tick(2);
        pin_in[9] = 1'b1;
        begin
            int highs;
            highs = 0;
            for (int k = 0; k < 8; k++) begin
                tick(1);
                if (irq_out) highs++;
            end
            check("R6 single irq pulse", highs, 32'd1);
        end
        rd_reg(6'h08, 16'h0000, "R6 status not held");
        tick(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule